// File: doc/BRIEF.md
# Paced Buffer-to-Memory DMA Engine

This engine copies bytes out of a 16 KB staging buffer into one of several destination memories: a sound-sample RAM, a program RAM, or a shared work RAM. The work RAM can be split into two banks or used as one unified space. A 3-bit mode field selects the destination. A start strobe loads a byte count and a source address, and the engine then moves `count + 1` bytes. The rate is capped at one byte per 16 clocks, and the budget is released in whole groups of 8 bytes.

Program RAM and unified work RAM can be owned by another processor. When that processor holds the memory, the engine halts and its pacing budget stops accruing. When the memory is handed back, the engine resumes with its pacing restarted from that moment. Split-bank work RAM never halts. Rewriting the mode field while a transfer is active redirects the rest of the transfer to the newly decoded destination and restarts the destination address at 0. Completion raises a one-cycle done pulse and, when enabled, a level interrupt.

The destination write port is a valid/ready stream. Once `dst_valid` is high, `dst_sel`, `dst_addr` and `dst_data` stay stable until `dst_ready` accepts the byte. The one exception is dropping `xfer_en`, which withdraws the byte at once. The source buffer is read asynchronously: `src_data` must reflect `src_addr` in the same cycle.

Top module: `paced_dma`

## Requirements
- R1: Mode 4 writes to the sound RAM (`dst_sel`=0) and mode 5 to the program RAM (`dst_sel`=1). Mode 7 writes to work RAM: bank 0 (`dst_sel`=2) when `wram_split`=1 and `wram_bank`=0, bank 1 (`dst_sel`=3) when `wram_split`=1 and `wram_bank`=1, and the unified space (`dst_sel`=4) when `wram_split`=0. Every other mode (including host-read codes 2 and 3) writes nothing and gives no done.
- R2: After start (or resume), the first group's first byte is offered 129 clocks after the starting edge, and group k begins 128·k clocks later. With `dst_ready` high, the bytes of a group go out on consecutive clocks, at most 8 per group.
- R3: A transfer moves exactly `count_in + 1` bytes. When fewer than 8 bytes remain, the final group carries all of them.
- R4: Byte i carries the buffer byte at `(src_addr_in + i) mod 2^14`. The destination address starts at 0 after a mode write, advances by one per byte, and wraps at the destination memory size.
- R5: A program-RAM transfer started while `prg_other`=1 writes nothing until `prg_other` falls. It then proceeds with the R2 timing measured from the release edge.
- R6: If `prg_other` rises during a program-RAM run, no new group starts until it falls. A group already in flight finishes.
- R7: Unified work-RAM transfers halt while `wram_other`=1. Split-bank transfers ignore `wram_other`.
- R8: A mode write during an active transfer takes effect between groups. The remaining bytes go to the newly decoded destination, starting at address 0, and the source continues in sequence.
- R9: `start` has no effect while `xfer_en`=0.
- R10: Dropping `xfer_en` aborts a running or a halted transfer. No further bytes are written and no done is given.
- R11: Reset leaves the engine idle with `dst_valid`, `done` and `irq` low. Completion gives `done` for exactly one clock. `irq` goes high with it when `irq_en`=1 and stays high until `irq_ack`.
- R12: While `dst_valid`=1 and `dst_ready`=0, the offered byte, its address and its select do not change, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_en | input | 1 | Transfer enable; low aborts |
| start | input | 1 | Start strobe |
| count_in | input | 14 | Byte count minus one |
| src_addr_in | input | 14 | First source address |
| mode_wr | input | 1 | Mode field write strobe |
| mode_in | input | 3 | Destination mode code |
| wram_split | input | 1 | Work RAM split into two banks |
| wram_bank | input | 1 | Bank used in split mode |
| prg_other | input | 1 | Other processor owns program RAM |
| wram_other | input | 1 | Other processor owns unified work RAM |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt clear |
| src_addr | output | 14 | Buffer read address |
| src_data | input | 8 | Buffer read data (same cycle) |
| dst_valid | output | 1 | Byte offered |
| dst_ready | input | 1 | Destination accepts byte |
| dst_sel | output | 3 | Destination select |
| dst_addr | output | 19 | Destination address |
| dst_data | output | 8 | Destination byte |
| done | output | 1 | Completion pulse |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a change of ownership or mode that lands exactly between two groups of a running transfer. The bench waits until the monitor has counted the eighth accepted byte, so the emitter is known to be idle. Only then does it raise `prg_other` or write a new mode, and it compares later byte counts, selects and addresses against the expected split. Resume timing is measured from the edge that samples the release, which shows that the pacing budget restarts instead of carrying over.

// File: rtl/paced_dma_pkg.sv
package paced_dma_pkg;
  typedef enum logic [2:0] {
    TGT_SND   = 3'd0,
    TGT_PRG   = 3'd1,
    TGT_WB0   = 3'd2,
    TGT_WB1   = 3'd3,
    TGT_WFULL = 3'd4
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } state_e;

  function automatic logic owned_elsewhere(tgt_e t, logic prg_o, logic wram_o);
    return (t == TGT_PRG && prg_o) || (t == TGT_WFULL && wram_o);
  endfunction
endpackage

// File: rtl/paced_dma_decode.sv
module paced_dma_decode
  import paced_dma_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       split,
  input  logic       bank,
  output logic       is_dma,
  output tgt_e       tgt
);
  always_comb begin
    is_dma = 1'b1;
    tgt    = TGT_SND;
    case (mode)
      3'd4: tgt = TGT_SND;
      3'd5: tgt = TGT_PRG;
      3'd7: tgt = split ? (bank ? TGT_WB1 : TGT_WB0) : TGT_WFULL;
      default: is_dma = 1'b0;
    endcase
  end
endmodule

// File: rtl/paced_dma_pacer.sv
module paced_dma_pacer #(
  parameter int LIM = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic grant
);
  localparam int CW = $clog2(LIM);
  localparam logic [CW-1:0] TOP = CW'(LIM - 1);

  logic [CW-1:0] credit;

  assign grant = run && !restart && (credit == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)  credit <= '0;
    else if (run)           credit <= (credit == TOP) ? '0 : credit + 1'b1;
  end
endmodule

// File: rtl/paced_dma.sv
module paced_dma
  import paced_dma_pkg::*;
#(
  parameter int SRC_AW    = 14,
  parameter int CNT_W     = 14,
  parameter int SND_AW    = 16,
  parameter int PRG_AW    = 19,
  parameter int WB_AW     = 17,
  parameter int WF_AW     = 18,
  parameter int BYTE_CLKS = 16,
  parameter int GROUP     = 8,
  localparam int M1       = (SND_AW > PRG_AW) ? SND_AW : PRG_AW,
  localparam int M2       = (WB_AW > WF_AW) ? WB_AW : WF_AW,
  localparam int DST_AW   = (M1 > M2) ? M1 : M2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_en,
  input  logic              start,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [SRC_AW-1:0] src_addr_in,
  input  logic              mode_wr,
  input  logic [2:0]        mode_in,
  input  logic              wram_split,
  input  logic              wram_bank,
  input  logic              prg_other,
  input  logic              wram_other,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic [SRC_AW-1:0] src_addr,
  input  logic [7:0]        src_data,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [2:0]        dst_sel,
  output logic [DST_AW-1:0] dst_addr,
  output logic [7:0]        dst_data,
  output logic              done,
  output logic              irq
);
  localparam int EW = $clog2(GROUP + 1);
  localparam logic [DST_AW-1:0] SND_M = DST_AW'((64'd1 << SND_AW) - 1);
  localparam logic [DST_AW-1:0] PRG_M = DST_AW'((64'd1 << PRG_AW) - 1);
  localparam logic [DST_AW-1:0] WB_M  = DST_AW'((64'd1 << WB_AW) - 1);
  localparam logic [DST_AW-1:0] WF_M  = DST_AW'((64'd1 << WF_AW) - 1);

  state_e            state, state_n;
  tgt_e              tgt;
  logic [2:0]        mode_q, mode_new;
  logic              mode_pend;
  logic [CNT_W-1:0]  remain;
  logic [SRC_AW-1:0] src_ptr;
  logic [DST_AW-1:0] dst_ptr, wrap_mask;
  logic [EW-1:0]     emit_left;
  logic              last_grp, grant_pend, grant;

  logic dec_a_dma, dec_b_dma;
  tgt_e dec_a_tgt, dec_b_tgt;

  paced_dma_decode u_dec_start (.mode(mode_q),   .split(wram_split), .bank(wram_bank),
                                .is_dma(dec_a_dma), .tgt(dec_a_tgt));
  paced_dma_decode u_dec_mode  (.mode(mode_new), .split(wram_split), .bank(wram_bank),
                                .is_dma(dec_b_dma), .tgt(dec_b_tgt));

  logic idle_emit, apply_mode, halt_cond, take, beat, finish, going_run;
  assign idle_emit  = (emit_left == '0);
  assign apply_mode = mode_pend && idle_emit;
  assign halt_cond  = owned_elsewhere(tgt, prg_other, wram_other);
  assign beat       = dst_valid && dst_ready;
  assign finish     = beat && last_grp && (emit_left == EW'(1));
  assign take       = (state == ST_RUN) && grant_pend && idle_emit && !mode_pend && !halt_cond;
  assign going_run  = (state != ST_RUN) && (state_n == ST_RUN);

  always_comb begin
    state_n = state;
    if (!xfer_en)
      state_n = ST_IDLE;
    else if (start)
      state_n = !dec_a_dma ? ST_IDLE :
                owned_elsewhere(dec_a_tgt, prg_other, wram_other) ? ST_HALT : ST_RUN;
    else if (apply_mode && state != ST_IDLE)
      state_n = !dec_b_dma ? ST_IDLE :
                owned_elsewhere(dec_b_tgt, prg_other, wram_other) ? ST_HALT : ST_RUN;
    else if (finish)
      state_n = ST_IDLE;
    else if (state == ST_RUN && idle_emit && halt_cond)
      state_n = ST_HALT;
    else if (state == ST_HALT && !halt_cond && !mode_pend)
      state_n = ST_RUN;
  end

  paced_dma_pacer #(.LIM(BYTE_CLKS * GROUP)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_RUN), .restart(going_run), .grant(grant)
  );

  always_comb begin
    case (tgt)
      TGT_SND:          wrap_mask = SND_M;
      TGT_PRG:          wrap_mask = PRG_M;
      TGT_WB0, TGT_WB1: wrap_mask = WB_M;
      default:          wrap_mask = WF_M;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tgt        <= TGT_SND;
      mode_q     <= 3'd0;
      mode_new   <= 3'd0;
      mode_pend  <= 1'b0;
      remain     <= '0;
      src_ptr    <= '0;
      dst_ptr    <= '0;
      emit_left  <= '0;
      last_grp   <= 1'b0;
      grant_pend <= 1'b0;
      done       <= 1'b0;
      irq        <= 1'b0;
    end else begin
      state <= state_n;
      done  <= finish && xfer_en && !start;

      if (irq_ack)                               irq <= 1'b0;
      else if (finish && xfer_en && !start && irq_en) irq <= 1'b1;

      if (mode_wr) begin
        mode_new  <= mode_in;
        mode_pend <= 1'b1;
      end else if (apply_mode) begin
        mode_pend <= 1'b0;
      end

      if (apply_mode) begin
        mode_q  <= mode_new;
        dst_ptr <= '0;
      end else if (beat) begin
        dst_ptr <= (dst_ptr + 1'b1) & wrap_mask;
      end

      if (!xfer_en) begin
        emit_left  <= '0;
        grant_pend <= 1'b0;
      end else if (start) begin
        remain     <= count_in;
        src_ptr    <= src_addr_in;
        tgt        <= dec_a_tgt;
        emit_left  <= '0;
        grant_pend <= 1'b0;
      end else begin
        if (apply_mode && state != ST_IDLE && dec_b_dma)
          tgt <= dec_b_tgt;
        if (state_n != ST_RUN || going_run)
          grant_pend <= 1'b0;
        else
          grant_pend <= (grant_pend && !take) || grant;
        if (take) begin
          if (remain < CNT_W'(GROUP)) begin
            emit_left <= EW'(remain) + 1'b1;
            last_grp  <= 1'b1;
          end else begin
            emit_left <= EW'(GROUP);
            last_grp  <= 1'b0;
            remain    <= remain - CNT_W'(GROUP);
          end
        end else if (beat) begin
          emit_left <= emit_left - 1'b1;
          src_ptr   <= src_ptr + 1'b1;
        end
      end
    end
  end

  assign src_addr  = src_ptr;
  assign dst_valid = !idle_emit;
  assign dst_sel   = tgt;
  assign dst_addr  = dst_ptr;
  assign dst_data  = src_data;
endmodule

// File: rtl/paced_dma_chk.sv
module paced_dma_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_en,
  input logic          start,
  input logic          dst_valid,
  input logic          dst_ready,
  input logic [2:0]    dst_sel,
  input logic [AW-1:0] dst_addr,
  input logic          done,
  input logic          irq,
  input logic          irq_ack
);
  // R12: offered byte held under back-pressure
  a_r12_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready && xfer_en && !start) |=>
      (dst_valid && $stable(dst_addr) && $stable(dst_sel)));

  // R10: dropping enable withdraws the stream
  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> (!dst_valid && !done));

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: irq only rises with completion
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);

  // R11: acknowledge clears irq
  a_r11_irq_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);

  // R1: select stays within the defined targets
  a_r1_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> (dst_sel <= 3'd4));
endmodule

bind paced_dma paced_dma_chk #(.AW(DST_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .start(start),
  .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_sel(dst_sel),
  .dst_addr(dst_addr), .done(done), .irq(irq), .irq_ack(irq_ack)
);

// File: tb/paced_dma_test.sv
`timescale 1ns/1ps
module paced_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_en = 1'b1, start = 1'b0, mode_wr = 1'b0;
  logic [13:0] count_in = '0, src_addr_in = '0, src_addr;
  logic [2:0]  mode_in = '0, dst_sel;
  logic        wram_split = 1'b0, wram_bank = 1'b0, prg_other = 1'b0, wram_other = 1'b0;
  logic        irq_en = 1'b0, irq_ack = 1'b0;
  logic [7:0]  src_data, dst_data;
  logic        dst_valid, dst_ready = 1'b1, done, irq;
  logic [18:0] dst_addr;

  always #4 clk = ~clk;

  function automatic logic [7:0] bufv(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
  endfunction
  assign src_data = bufv(src_addr);

  paced_dma #(.SND_AW(4)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .start(start), .count_in(count_in),
    .src_addr_in(src_addr_in), .mode_wr(mode_wr), .mode_in(mode_in),
    .wram_split(wram_split), .wram_bank(wram_bank), .prg_other(prg_other),
    .wram_other(wram_other), .irq_en(irq_en), .irq_ack(irq_ack),
    .src_addr(src_addr), .src_data(src_data), .dst_valid(dst_valid),
    .dst_ready(dst_ready), .dst_sel(dst_sel), .dst_addr(dst_addr),
    .dst_data(dst_data), .done(done), .irq(irq)
  );

  int cyc = 0, nchk = 0, nfail = 0, nw = 0, ndone = 0;
  bit bp = 1'b0;
  int w_sel[64], w_addr[64], w_data[64], w_cyc[64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    dst_ready = bp ? ((cyc % 3) != 0) : 1'b1;
    if (rst_n && dst_valid && dst_ready && nw < 64) begin
      w_sel[nw]  = dst_sel;
      w_addr[nw] = dst_addr;
      w_data[nw] = dst_data;
      w_cyc[nw]  = cyc;
      nw++;
    end
    if (rst_n && done) ndone++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    nw = 0; ndone = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [2:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_in = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic go(input int cnt, input int src, output int c0);
    @(negedge clk); count_in = 14'(cnt); src_addr_in = 14'(src); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0; c0 = cyc;
  endtask

  task automatic wait_nw(input int n, input int lim);
    for (int i = 0; i < lim && nw < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(1);
  endtask

  task automatic check_stream(input string req, input int n, input int sel, input int src0,
                              input int amask);
    for (int i = 0; i < n; i++) begin
      chk(w_sel[i] == sel, req, w_sel[i], sel);
      chk(w_addr[i] == (i & amask), req, w_addr[i], i & amask);
      chk(w_data[i] == bufv(14'(src0 + i)), req, w_data[i], bufv(14'(src0 + i)));
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(dst_valid == 1'b0, "R11 reset valid", dst_valid, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    chk(irq == 1'b0, "R11 reset irq", irq, 0);
  endtask

  task automatic t_sound_pacing();
    int c0;
    wr_mode(3'd4); irq_en = 1'b1; clr();
    go(19, 14'h3FFC, c0);
    wait_nw(20, 800); idle(4);
    chk(nw == 20, "R3 count+1 bytes", nw, 20);
    chk(ndone == 1, "R11 one done", ndone, 1);
    check_stream("R4 R1 sound stream wrap", 20, 0, 14'h3FFC, 15);
    chk(w_cyc[0] - c0 == 129, "R2 first group", w_cyc[0] - c0, 129);
    chk(w_cyc[7] - w_cyc[0] == 7, "R2 group back-to-back", w_cyc[7] - w_cyc[0], 7);
    chk(w_cyc[8] - c0 == 257, "R2 second group", w_cyc[8] - c0, 257);
    chk(w_cyc[16] - c0 == 385, "R2 final group", w_cyc[16] - c0, 385);
    chk(irq == 1'b1, "R11 irq raised", irq, 1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(irq == 1'b0, "R11 irq ack", irq, 0);
  endtask

  task automatic t_prog_small();
    int c0;
    wr_mode(3'd5); irq_en = 1'b0; clr();
    go(7, 100, c0);
    wait_nw(8, 400); idle(4);
    chk(nw == 8, "R3 count 7 one group", nw, 8);
    check_stream("R1 program target", 8, 1, 100, 32'h7FFFF);
    chk(irq == 1'b0, "R11 irq disabled", irq, 0);
    chk(ndone == 1, "R11 done without irq", ndone, 1);
    wr_mode(3'd5); clr();
    go(0, 5, c0);
    wait_nw(1, 400); idle(20);
    chk(nw == 1, "R3 count 0 one byte", nw, 1);
  endtask

  task automatic t_invalid();
    logic [2:0] codes [5] = '{3'd2, 3'd3, 3'd6, 3'd0, 3'd1};
    int c0;
    foreach (codes[k]) begin
      wr_mode(codes[k]); clr();
      go(3, 0, c0);
      idle(300);
      chk(nw == 0 && ndone == 0, "R1 non-DMA code writes nothing", nw, 0);
    end
  endtask

  task automatic t_work();
    int c0, c1;
    wram_split = 1'b1; wram_bank = 1'b0; wram_other = 1'b1;
    wr_mode(3'd7); clr(); go(7, 0, c0); wait_nw(8, 400); idle(4);
    chk(nw == 8 && w_sel[0] == 2, "R7 split bank0 ignores owner", w_sel[0], 2);
    wram_bank = 1'b1;
    wr_mode(3'd7); clr(); go(7, 0, c0); wait_nw(8, 400); idle(4);
    chk(nw == 8 && w_sel[0] == 3, "R1 split bank1", w_sel[0], 3);
    wram_split = 1'b0;
    wr_mode(3'd7); clr(); go(7, 0, c0); idle(400);
    chk(nw == 0, "R7 unified halts while owned", nw, 0);
    @(negedge clk); wram_other = 1'b0; @(posedge clk); @(negedge clk); c1 = cyc;
    wait_nw(8, 400); idle(4);
    chk(nw == 8 && w_sel[0] == 4, "R7 unified resumes", w_sel[0], 4);
    chk(w_cyc[0] - c1 == 129, "R7 resume timing", w_cyc[0] - c1, 129);
  endtask

  task automatic t_prg_halt_start();
    int c0, c1;
    prg_other = 1'b1; wr_mode(3'd5); clr();
    go(15, 40, c0); idle(400);
    chk(nw == 0, "R5 halted at start", nw, 0);
    @(negedge clk); prg_other = 1'b0; @(posedge clk); @(negedge clk); c1 = cyc;
    wait_nw(16, 600); idle(4);
    chk(w_cyc[0] - c1 == 129, "R5 resume pacing restarts", w_cyc[0] - c1, 129);
    chk(nw == 16 && ndone == 1, "R5 completes after release", nw, 16);
    check_stream("R5 stream after resume", 16, 1, 40, 32'h7FFFF);
  endtask

  task automatic t_prg_halt_mid();
    int c0;
    wr_mode(3'd5); clr();
    go(31, 0, c0); wait_nw(8, 400);
    prg_other = 1'b1; idle(500);
    chk(nw == 8, "R6 no group while owned", nw, 8);
    prg_other = 1'b0;
    wait_nw(32, 1200); idle(4);
    chk(nw == 32 && ndone == 1, "R6 finishes after release", nw, 32);
    check_stream("R6 stream continuity", 32, 1, 0, 32'h7FFFF);
  endtask

  task automatic t_mode_mid();
    int c0;
    wr_mode(3'd4); clr();
    go(23, 200, c0); wait_nw(8, 400);
    wr_mode(3'd5);
    wait_nw(24, 800); idle(4);
    chk(nw == 24, "R8 total unchanged", nw, 24);
    for (int i = 8; i < 24; i++) begin
      chk(w_sel[i] == 1, "R8 new destination", w_sel[i], 1);
      chk(w_addr[i] == i - 8, "R8 address restarted", w_addr[i], i - 8);
      chk(w_data[i] == bufv(14'(200 + i)), "R8 source continues", w_data[i], bufv(14'(200 + i)));
    end
  endtask

  task automatic t_start_ignored();
    int c0;
    wr_mode(3'd4); clr();
    xfer_en = 1'b0; go(7, 0, c0); idle(300);
    chk(nw == 0, "R9 start ignored when disabled", nw, 0);
    xfer_en = 1'b1; idle(300);
    chk(nw == 0, "R9 no late start", nw, 0);
  endtask

  task automatic t_abort();
    int c0;
    wr_mode(3'd4); clr();
    go(31, 0, c0); wait_nw(8, 400);
    xfer_en = 1'b0; idle(500);
    chk(nw == 8 && ndone == 0, "R10 running abort", nw, 8);
    xfer_en = 1'b1;
    prg_other = 1'b1; wr_mode(3'd5); clr();
    go(7, 0, c0); idle(20);
    xfer_en = 1'b0; idle(2); prg_other = 1'b0; idle(2); xfer_en = 1'b1; idle(400);
    chk(nw == 0 && ndone == 0, "R10 halted abort", nw, 0);
  endtask

  task automatic t_backpressure();
    int c0;
    bp = 1'b1; wr_mode(3'd4); clr();
    go(15, 300, c0); wait_nw(16, 800); idle(4);
    chk(nw == 16, "R12 no loss under back-pressure", nw, 16);
    check_stream("R12 stream order", 16, 0, 300, 15);
    bp = 1'b0;
  endtask

  initial begin
    t_reset();
    t_sound_pacing();
    t_prog_small();
    t_invalid();
    t_work();
    t_prg_halt_start();
    t_prg_halt_mid();
    t_mode_mid();
    t_start_ignored();
    t_abort();
    t_backpressure();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule